// File: doc/BRIEF.md
# Fixed-Point Rounding Increment Unit

This block decides whether a value that is about to be arithmetically shifted right must be bumped by one to be correctly rounded. It takes a 64-bit operand, a 7-bit right-shift distance and a 2-bit rounding-mode code. It returns a single increment bit. The consuming datapath performs the shift and adds this bit to the shifted result. Any saturation also belongs to that datapath.

The unit inspects three things. The first is the highest bit that the shift discards (the guard bit). The second is the OR of all discarded bits below the guard bit. The third is the lowest surviving bit. The two-bit mode code picks how these three combine. All four codes are defined, so no encoding is illegal.

An output register is fitted by default. With it, the result appears one cycle after a valid input, and a valid flag travels alongside it. A parameter can remove the register, which turns the unit into pure combinational logic.

Top module: `rnd_incr_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_valid` and `out_round` are both 0.
- R2: Mode code 0 (nearest, ties up): the increment equals operand bit `shift-1`.
- R3: Mode code 1 (nearest, ties to even), for a shift of 2 to 64: the increment is bit `shift-1` ANDed with the OR of two terms. One term is "any operand bit below `shift-1` is 1". The other term is the retained bit `shift`, which counts as 0 when the shift is 64.
- R4: Mode code 1 with a shift of exactly 1: the increment is operand bit 0 AND operand bit 1.
- R5: Mode code 2 (truncate): the increment is always 0.
- R6: Mode code 3 (round to odd): the increment is 1 only when the retained bit `shift` is 0 and at least one operand bit below `shift` is 1.
- R7: A shift of 0, or any shift above 64 (65 to 127), gives an increment of 0 in every mode.
- R8: A shift of 64 discards the whole word. In this case the guard is bit 63, the sticky test covers every bit, and the retained bit is taken as 0.
- R9: With the register fitted, `out_valid` equals `in_valid` of the previous cycle. `out_round` takes the result for the inputs of a valid cycle and keeps its value through cycles in which `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand, shift and mode are valid this cycle |
| in_value | input | 64 | Operand that is about to be shifted |
| in_shift | input | 7 | Right-shift distance |
| in_mode | input | 2 | Rounding mode: 0 nearest-up, 1 nearest-even, 2 truncate, 3 odd |
| out_valid | output | 1 | Result valid |
| out_round | output | 1 | Increment bit to add after the shift |

## Verification
A faulty mask or bit selector shows up as a wrong `out_round` one cycle after the input that hits it. Such faults tend to hide at the ends of the shift range (1, 63, 64 and 65), so the directed cases aim at those shifts. A swapped mode decode shows up on the first tie value, where the even and up modes disagree. A stale valid or hold register shows up on the first idle cycle, as an unexpected `out_valid` or a changed `out_round`. Random operands with a mix of sparse and dense bit patterns cover the sticky OR over every bit position.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR_UP   = 2'd0,
    RM_NEAR_EVEN = 2'd1,
    RM_DOWN      = 2'd2,
    RM_ODD       = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/rnd_mask_gen.sv
// Produces discard masks and one-hot selectors from the shift distance.
module rnd_mask_gen #(
  parameter int DATA_W  = 64,
  parameter int SHIFT_W = 7
) (
  input  logic [SHIFT_W-1:0] shift,
  output logic [DATA_W-1:0]  all_mask,   // bits below shift
  output logic [DATA_W-1:0]  low_mask,   // bits below shift-1
  output logic [DATA_W-1:0]  guard_sel,  // one-hot at shift-1
  output logic [DATA_W-1:0]  lsb_sel,    // one-hot at shift
  output logic               in_range    // 1 <= shift <= DATA_W
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign all_mask[i]  = (shift > SHIFT_W'(i));
    assign low_mask[i]  = (shift > SHIFT_W'(i + 1));
    assign guard_sel[i] = (shift == SHIFT_W'(i + 1));
    assign lsb_sel[i]   = (shift == SHIFT_W'(i));
  end
  assign in_range = (shift != '0) && (shift <= SHIFT_W'(DATA_W));
endmodule

// File: rtl/rnd_bit_pick.sv
// Reduces the operand through the masks to guard, retained and sticky terms.
module rnd_bit_pick #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] all_mask,
  input  logic [DATA_W-1:0] low_mask,
  input  logic [DATA_W-1:0] guard_sel,
  input  logic [DATA_W-1:0] lsb_sel,
  output logic              guard,
  output logic              kept_lsb,
  output logic              low_any,
  output logic              all_any
);
  assign guard    = |(value & guard_sel);
  assign kept_lsb = |(value & lsb_sel);
  assign low_any  = |(value & low_mask);
  assign all_any  = |(value & all_mask);
endmodule

// File: rtl/rnd_decide.sv
// Combines the reduced terms according to the selected mode.
module rnd_decide
  import rnd_pkg::*;
(
  input  rnd_mode_e mode,
  input  logic      in_range,
  input  logic      guard,
  input  logic      kept_lsb,
  input  logic      low_any,
  input  logic      all_any,
  output logic      incr
);
  logic raw;
  always_comb begin
    unique case (mode)
      RM_NEAR_UP:   raw = guard;
      RM_NEAR_EVEN: raw = guard & (low_any | kept_lsb);
      RM_DOWN:      raw = 1'b0;
      RM_ODD:       raw = ~kept_lsb & all_any;
      default:      raw = 1'b0;
    endcase
  end
  assign incr = raw & in_range;
endmodule

// File: rtl/rnd_incr_unit.sv
module rnd_incr_unit
  import rnd_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHIFT_W = 7,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_value,
  input  logic [SHIFT_W-1:0] in_shift,
  input  logic [1:0]         in_mode,
  output logic               out_valid,
  output logic               out_round
);
  logic [DATA_W-1:0] all_mask, low_mask, guard_sel, lsb_sel;
  logic in_range, guard, kept_lsb, low_any, all_any, incr;

  rnd_mask_gen #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_mask (
    .shift(in_shift), .all_mask(all_mask), .low_mask(low_mask),
    .guard_sel(guard_sel), .lsb_sel(lsb_sel), .in_range(in_range)
  );

  rnd_bit_pick #(.DATA_W(DATA_W)) u_pick (
    .value(in_value), .all_mask(all_mask), .low_mask(low_mask),
    .guard_sel(guard_sel), .lsb_sel(lsb_sel), .guard(guard),
    .kept_lsb(kept_lsb), .low_any(low_any), .all_any(all_any)
  );

  rnd_decide u_dec (
    .mode(rnd_mode_e'(in_mode)), .in_range(in_range), .guard(guard),
    .kept_lsb(kept_lsb), .low_any(low_any), .all_any(all_any), .incr(incr)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        out_round <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) out_round <= incr;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_round = incr;
  end
endmodule

// File: rtl/rnd_incr_chk.sv
module rnd_incr_chk #(
  parameter int DATA_W  = 64,
  parameter int SHIFT_W = 7,
  parameter bit OUT_REG = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [DATA_W-1:0]  in_value,
  input logic [SHIFT_W-1:0] in_shift,
  input logic [1:0]         in_mode,
  input logic               out_valid,
  input logic               out_round
);
  logic [DATA_W-1:0] shr_g, shr_l;
  logic ok_rng;
  assign shr_g  = in_value >> (in_shift - SHIFT_W'(1));
  assign shr_l  = in_value >> in_shift;
  assign ok_rng = (in_shift != '0) && (in_shift <= SHIFT_W'(DATA_W));

  if (OUT_REG) begin : g_chk
    // R1
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> (!out_valid && !out_round));
    // R9
    a_r9_valid_follow: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    a_r9_valid_idle: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      (out_valid == 1'b0 && !in_valid && !$past(rst)) |=> $stable(out_round));
    // R2
    a_r2_near_up: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_mode == 2'd0 && ok_rng) |=> (out_round == $past(shr_g[0])));
    // R5
    a_r5_truncate: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_mode == 2'd2) |=> !out_round);
    // R6
    a_r6_odd_kept: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_mode == 2'd3 && ok_rng && shr_l[0]) |=> !out_round);
    // R7
    a_r7_out_of_range: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !ok_rng) |=> !out_round);
  end
endmodule

bind rnd_incr_unit rnd_incr_chk #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .OUT_REG(OUT_REG))
  u_chk (.*);

// File: tb/rnd_incr_unit_tb.sv
module rnd_incr_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_value = '0;
  logic [6:0] in_shift = '0;
  logic [1:0] in_mode = '0;
  logic out_valid, out_round;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rnd_incr_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value),
    .in_shift(in_shift), .in_mode(in_mode), .out_valid(out_valid), .out_round(out_round)
  );

  function automatic logic ref_round(logic [DW-1:0] v, int s, int m);
    logic g, k, lo, al;
    if (s == 0 || s > DW) return 1'b0;
    g = v[s-1];
    k = (s < DW) ? v[s] : 1'b0;
    lo = 1'b0; al = 1'b0;
    for (int i = 0; i < s; i++) begin
      al |= v[i];
      if (i < s - 1) lo |= v[i];
    end
    case (m)
      0: return g;
      1: return g & (lo | k);
      2: return 1'b0;
      default: return ~k & al;
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (value=%h shift=%0d mode=%0d)",
               req, act, exp, in_value, in_shift, in_mode);
    end
  endtask

  // Drive one operand, then check the registered result one cycle later.
  task automatic run(string req, logic [DW-1:0] v, int s, int m);
    logic exp;
    @(negedge clk);
    in_valid = 1'b1; in_value = v; in_shift = 7'(s); in_mode = 2'(m);
    exp = ref_round(v, s, m);
    @(negedge clk);
    check({req, " valid"}, out_valid, 1'b1);
    check(req, out_round, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic held;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", out_valid, 1'b0);
    check("R1 round in reset", out_round, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", out_valid, 1'b0);
    check("R1 round after reset", out_round, 1'b0);

    // R2: ties up
    run("R2 guard set", 64'h0000_0000_0000_0008, 4, 0);
    run("R2 guard clear", 64'h0000_0000_0000_0017, 4, 0);
    run("R2 shift 1", 64'h1, 1, 0);
    // R3: ties to even
    run("R3 tie even kept", 64'h0000_0000_0000_0008, 4, 1);
    run("R3 tie odd kept", 64'h0000_0000_0000_0018, 4, 1);
    run("R3 above tie", 64'h0000_0000_0000_0009, 4, 1);
    run("R3 below tie", 64'h0000_0000_0000_0017 & 64'hF7, 4, 1);
    // R4
    run("R4 shift1 both", 64'h3, 1, 1);
    run("R4 shift1 b0 only", 64'h1, 1, 1);
    run("R4 shift1 b1 only", 64'h2, 1, 1);
    // R5
    run("R5 truncate", 64'hFFFF_FFFF_FFFF_FFFF, 10, 2);
    // R6
    run("R6 odd jam", 64'h0000_0000_0000_0001, 5, 3);
    run("R6 odd kept set", 64'h0000_0000_0000_0021, 5, 3);
    run("R6 odd exact", 64'h0000_0000_0000_0040, 5, 3);
    // R7
    for (int m = 0; m < 4; m++) begin
      run("R7 shift 0", 64'hFFFF_FFFF_FFFF_FFFF, 0, m);
      run("R7 shift 65", 64'hFFFF_FFFF_FFFF_FFFF, 65, m);
      run("R7 shift 127", 64'hFFFF_FFFF_FFFF_FFFF, 127, m);
    end
    // R8
    run("R8 s64 up", 64'h8000_0000_0000_0000, 64, 0);
    run("R8 s64 even tie", 64'h8000_0000_0000_0000, 64, 1);
    run("R8 s64 even low", 64'h8000_0000_0000_0001, 64, 1);
    run("R8 s64 odd", 64'h0000_0000_0000_0001, 64, 3);
    run("R8 s63 odd kept", 64'h8000_0000_0000_0001, 63, 3);

    // R9: idle cycle keeps round, drops valid
    run("R9 load one", 64'h8, 4, 0);
    held = out_round;
    @(negedge clk);
    in_valid = 1'b0; in_value = '0; in_shift = 7'd1; in_mode = 2'd2;
    @(negedge clk);
    check("R9 valid idle", out_valid, 1'b0);
    check("R9 round held", out_round, held);

    // Random mix for R2 R3 R6 R8
    for (int n = 0; n < 3000; n++) begin
      logic [DW-1:0] v;
      int s, m;
      v = {$urandom, $urandom};
      case ($urandom % 3)
        0: v = v & {$urandom, $urandom} & {$urandom, $urandom};
        1: v = v | {$urandom, $urandom};
        default: ;
      endcase
      s = ($urandom % 8 == 0) ? int'($urandom % 128) : int'($urandom % 65);
      m = int'($urandom % 4);
      run("R2/R3/R6 random", v, s, m);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule